// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous two-bit dynamic memory. The host gives it one access at a time: an address, a write flag, two data bits and a two-bit lane mask, with a valid/ready handshake. The controller converts each access into active-low strobe sequences on the memory pins. These are a row strobe, one column strobe per data bit, a write strobe and an output enable, together with a multiplexed address bus and a bidirectional two-bit data bus. Every timing limit is a parameter in nanoseconds. Each limit is turned into whole clock cycles; minimums are rounded up and the maximum row-open time is rounded down.

A row stays open after an access. A later access to the same row is served with a column cycle only. An access to any other row, a refresh request, or an open row nearing its maximum low time closes the row first and then waits out the full precharge. Writes are early writes: the write strobe goes low one cycle before the column strobe falls, and the output enable stays high. A lane whose mask bit is clear keeps its column strobe high, so that bit is neither written nor read. Refresh is requested through a level input. Between accesses the controller answers it with a column-before-row refresh cycle and gives a one-cycle done pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row is the upper ROW_W bits of req_addr and the column is the lower COL_W bits. mem_addr carries the row when row_stb_n falls and keeps it for at least the row hold time. It then carries the column from the cycle before the column strobes fall until they rise.
- R2: A read returns rsp_valid for one cycle with rsp_rdata bit i equal to the stored bit i when req_lane[i] is 1, and 0 when req_lane[i] is 0.
- R3: A write drives wr_en_n low at least one cycle before any column strobe falls, keeps out_en_n high while wr_en_n is low, and drives mem_dq only during the write.
- R4: col_stb_n[i] serves data bit i and falls only when req_lane[i] is 1. A write leaves the stored bit of a lane whose mask bit is 0 unchanged.
- R5: An access to the open row, with time left, produces no new row strobe fall.
- R6: An access to a different row first raises row_stb_n, then opens the new row, so each such access gives exactly one row strobe fall.
- R7: row_stb_n stays low for at least ceil(T_RAS_NS/CLK_NS) cycles. It stays high for at least max(ceil(T_RP_NS/CLK_NS), ceil(T_RC_NS/CLK_NS) minus the low minimum) cycles.
- R8: Each column strobe stays low for at least ceil(T_CAS_NS/CLK_NS) cycles.
- R9: row_stb_n is never low for more than floor(T_RASP_NS/CLK_NS) cycles, even while the host is idle.
- R10: When ref_req is high between accesses, the controller closes any open row with full precharge. It then drives both column strobes low for at least ceil(T_CSR_NS/CLK_NS) cycles before row_stb_n falls, with wr_en_n high. It pulses ref_done when the row strobe rises, and no stored data changes.
- R11: After reset all strobes are high, mem_dq is not driven and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Request taken at this clock edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and column (lower bits) |
| req_wdata | input | 2 | Write data, bit i to lane i |
| req_lane | input | 2 | Lane mask, bit i enables data bit i |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 2 | Read data, masked by lane |
| ref_req | input | 1 | Refresh request level |
| ref_done | output | 1 | Refresh finished pulse |
| row_stb_n | output | 1 | Row address strobe, active low |
| col_stb_n | output | 2 | Column strobe per data bit, active low |
| wr_en_n | output | 1 | Write strobe, active low |
| out_en_n | output | 1 | Output enable, active low |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_dq | inout | 2 | Bidirectional data |

## Verification
Some properties are checked on every cycle at the pins. These are the minimum low and high widths of the row strobe, the minimum column strobe width, the cap on row-open time, early write order with the output enable held off, and column strobe setup with the write strobe high before a refresh row strobe. Only the bench's scenarios can show the rest. That covers data integrity across a full address sweep, lane masking on reads and writes, and the row strobe fall counts that tell a page hit from a miss. It also covers a refresh that leaves memory contents intact.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CASL,
        ST_CASH,
        ST_CLOSE,
        ST_PRE,
        ST_RCSR,
        ST_RRAS,
        ST_RHOLD
    } fpm_st_e;

    function automatic int ceil_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_down_timer.sv
module fpm_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_row_guard.sv
module fpm_row_guard #(
    parameter int MIN_CYC = 12,
    parameter int MAX_CYC = 20000,
    parameter int MARGIN  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_stb_n,
    output logic min_met,
    output logic near_max
);
    localparam int AGE_W = $clog2(MAX_CYC + 2);

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          age_q <= '0;
        else if (row_stb_n)                  age_q <= '0;
        else if (age_q != AGE_W'(MAX_CYC))   age_q <= age_q + 1'b1;
    end

    // age counts completed low cycles; releasing now gives age+1 low cycles
    assign min_met  = (int'(age_q) >= MIN_CYC - 1);
    assign near_max = (int'(age_q) >= MAX_CYC - MARGIN);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 10,
    parameter int CLK_NS     = 5,
    parameter int T_RC_NS    = 110,
    parameter int T_RAS_NS   = 60,
    parameter int T_RP_NS    = 40,
    parameter int T_CAS_NS   = 15,
    parameter int T_CP_NS    = 10,
    parameter int T_PC_NS    = 40,
    parameter int T_CAC_NS   = 15,
    parameter int T_RCD_NS   = 20,
    parameter int T_RAH_NS   = 10,
    parameter int T_CAH_NS   = 10,
    parameter int T_CSR_NS   = 10,
    parameter int T_CHR_NS   = 10,
    parameter int T_RASP_NS  = 100000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [1:0]             req_wdata,
    input  logic [1:0]             req_lane,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_rdata,
    input  logic                   ref_req,
    output logic                   ref_done,
    output logic                   row_stb_n,
    output logic [1:0]             col_stb_n,
    output logic                   wr_en_n,
    output logic                   out_en_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    inout  wire  [1:0]             mem_dq
);
    localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int RAS_C  = ceil_cyc(T_RAS_NS, CLK_NS);
    localparam int RP_C   = max2(ceil_cyc(T_RP_NS, CLK_NS), ceil_cyc(T_RC_NS, CLK_NS) - RAS_C);
    localparam int CAS_C  = max2(max2(ceil_cyc(T_CAS_NS, CLK_NS), ceil_cyc(T_CAH_NS, CLK_NS)),
                                 ceil_cyc(T_CAC_NS, CLK_NS));
    localparam int CPW_C  = max2(ceil_cyc(T_CP_NS, CLK_NS), ceil_cyc(T_PC_NS, CLK_NS) - CAS_C - 2);
    localparam int ROW_C  = max2(ceil_cyc(T_RAH_NS, CLK_NS), ceil_cyc(T_RCD_NS, CLK_NS) - 1);
    localparam int CSR_C  = max2(ceil_cyc(T_CSR_NS, CLK_NS), 1);
    localparam int CHR_C  = max2(ceil_cyc(T_CHR_NS, CLK_NS), 1);
    localparam int MAX_C  = T_RASP_NS / CLK_NS;
    localparam int MARGIN = CAS_C + CPW_C + 5;
    localparam int TMAX   = max2(max2(max2(RP_C, CAS_C), max2(CPW_C, ROW_C)), max2(CSR_C, CHR_C));
    localparam int TW     = $clog2(TMAX + 1);

    typedef struct packed {
        fpm_st_e          st;
        logic             row_open;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             we;
        logic [1:0]       wdat;
        logic [1:0]       lane;
        logic             ras_n;
        logic [1:0]       cas_n;
        logic             we_n;
        logic             oe_n;
        logic             dq_oe;
        logic [1:0]       dq_out;
        logic [AW-1:0]    addr;
        logic             rsp_v;
        logic [1:0]       rdata;
        logic             ref_done;
    } ctrl_s;

    ctrl_s           q, d;
    logic            tmr_load, tmr_done, min_met, near_max, hit;
    logic [TW-1:0]   tmr_val;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;

    assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];
    assign hit     = q.row_open && (req_row == q.row);

    fpm_down_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .done(tmr_done)
    );

    fpm_row_guard #(.MIN_CYC(RAS_C), .MAX_CYC(MAX_C), .MARGIN(MARGIN)) u_guard (
        .clk(clk), .rst_n(rst_n), .row_stb_n(q.ras_n), .min_met(min_met), .near_max(near_max)
    );

    always_comb begin
        d          = q;
        d.rsp_v    = 1'b0;
        d.ref_done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        req_ready  = (q.st == ST_IDLE) && !ref_req && (!q.row_open || (hit && !near_max));
        unique case (q.st)
            ST_IDLE: begin
                if (q.row_open && (ref_req || near_max || (req_valid && !hit))) begin
                    d.st = ST_CLOSE;
                end else if (ref_req) begin
                    d.st     = ST_RCSR;
                    d.cas_n  = 2'b00;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CSR_C - 1);
                end else if (req_valid) begin
                    d.col  = req_col;
                    d.we   = req_we;
                    d.wdat = req_wdata;
                    d.lane = req_lane;
                    if (q.row_open) begin
                        d.st     = ST_COL;
                        d.addr   = AW'(req_col);
                        d.we_n   = !req_we;
                        d.oe_n   = req_we;
                        d.dq_oe  = req_we;
                        d.dq_out = req_wdata;
                    end else begin
                        d.st       = ST_ROW;
                        d.ras_n    = 1'b0;
                        d.addr     = AW'(req_row);
                        d.row      = req_row;
                        d.row_open = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(ROW_C - 1);
                    end
                end
            end
            ST_ROW: if (tmr_done) begin
                d.st     = ST_COL;
                d.addr   = AW'(q.col);
                d.we_n   = !q.we;
                d.oe_n   = q.we;
                d.dq_oe  = q.we;
                d.dq_out = q.wdat;
            end
            ST_COL: begin
                d.st     = ST_CASL;
                d.cas_n  = ~q.lane;
                tmr_load = 1'b1;
                tmr_val  = TW'(CAS_C - 1);
            end
            ST_CASL: if (tmr_done) begin
                d.st     = ST_CASH;
                d.cas_n  = 2'b11;
                d.we_n   = 1'b1;
                d.oe_n   = 1'b1;
                d.dq_oe  = 1'b0;
                d.rsp_v  = !q.we;
                d.rdata  = q.we ? q.rdata : (mem_dq & q.lane);
                tmr_load = 1'b1;
                tmr_val  = TW'(CPW_C - 1);
            end
            ST_CASH: if (tmr_done) d.st = ST_IDLE;
            ST_CLOSE: if (min_met) begin
                d.st       = ST_PRE;
                d.ras_n    = 1'b1;
                d.row_open = 1'b0;
                tmr_load   = 1'b1;
                tmr_val    = TW'(RP_C - 1);
            end
            ST_PRE: if (tmr_done) d.st = ST_IDLE;
            ST_RCSR: if (tmr_done) begin
                d.st     = ST_RRAS;
                d.ras_n  = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = TW'(CHR_C - 1);
            end
            ST_RRAS: if (tmr_done) begin
                d.st    = ST_RHOLD;
                d.cas_n = 2'b11;
            end
            ST_RHOLD: if (min_met) begin
                d.st       = ST_PRE;
                d.ras_n    = 1'b1;
                d.ref_done = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = TW'(RP_C - 1);
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 2'b11;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mem_dq    = q.dq_oe ? q.dq_out : 2'bzz;
    assign row_stb_n = q.ras_n;
    assign col_stb_n = q.cas_n;
    assign wr_en_n   = q.we_n;
    assign out_en_n  = q.oe_n;
    assign mem_addr  = q.addr;
    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rdata;
    assign ref_done  = q.ref_done;
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk
    import fpm_pkg::*;
#(
    parameter int CLK_NS    = 5,
    parameter int T_RC_NS   = 110,
    parameter int T_RAS_NS  = 60,
    parameter int T_RP_NS   = 40,
    parameter int T_CAS_NS  = 15,
    parameter int T_CSR_NS  = 10,
    parameter int T_RASP_NS = 100000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       row_stb_n,
    input logic [1:0] col_stb_n,
    input logic       wr_en_n,
    input logic       out_en_n
);
    localparam int RAS_C = ceil_cyc(T_RAS_NS, CLK_NS);
    localparam int RP_C  = max2(ceil_cyc(T_RP_NS, CLK_NS), ceil_cyc(T_RC_NS, CLK_NS) - RAS_C);
    localparam int CAS_C = ceil_cyc(T_CAS_NS, CLK_NS);
    localparam int CSR_C = ceil_cyc(T_CSR_NS, CLK_NS);
    localparam int MAX_C = T_RASP_NS / CLK_NS;
    localparam int SAT   = RP_C + 4;

    int lo_q, hi_q, c0_q, c1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 0; hi_q <= SAT; c0_q <= 0; c1_q <= 0;
        end else begin
            lo_q <= row_stb_n ? 0 : lo_q + 1;
            hi_q <= !row_stb_n ? 0 : ((hi_q >= SAT) ? SAT : hi_q + 1);
            c0_q <= col_stb_n[0] ? 0 : c0_q + 1;
            c1_q <= col_stb_n[1] ? 0 : c1_q + 1;
        end
    end

    assert_row_low_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_stb_n) |-> (lo_q >= RAS_C));
    assert_row_prech_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_stb_n) |-> (hi_q >= RP_C));
    assert_col0_low_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_stb_n[0]) |-> (c0_q >= CAS_C));
    assert_col1_low_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_stb_n[1]) |-> (c1_q >= CAS_C));
    assert_row_low_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_q <= MAX_C);
    assert_early_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(col_stb_n[0]) || $fell(col_stb_n[1])) && !wr_en_n) |-> $past(!wr_en_n));
    assert_write_no_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_n |-> out_en_n);
    assert_refresh_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_stb_n) && col_stb_n == 2'b00) |-> (wr_en_n && c0_q >= CSR_C && c1_q >= CSR_C));
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
    .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_RAS_NS(T_RAS_NS), .T_RP_NS(T_RP_NS),
    .T_CAS_NS(T_CAS_NS), .T_CSR_NS(T_CSR_NS), .T_RASP_NS(T_RASP_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n)
);

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
    localparam int RW = 3, CW = 3, AWT = RW + CW, N = 1 << AWT;
    // expected cycle counts for 5 ns clock and default timings, rasp 400 ns
    localparam int RAS_C = 12, RP_C = 10, CAS_C = 3, CSR_C = 2, MAX_C = 80;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic req_valid = 0, req_we = 0, ref_req = 0;
    logic [AWT-1:0] req_addr = '0;
    logic [1:0] req_wdata = '0, req_lane = '0;
    logic req_ready, rsp_valid, ref_done, row_stb_n, wr_en_n, out_en_n;
    logic [1:0] rsp_rdata, col_stb_n;
    logic [RW-1:0] mem_addr;
    wire  [1:0] mem_dq;

    fpm_dram_ctrl #(.ROW_W(RW), .COL_W(CW), .CLK_NS(5), .T_RASP_NS(400)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_lane(req_lane),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_done(ref_done),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n), .wr_en_n(wr_en_n), .out_en_n(out_en_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // memory model, sampled away from the active edge
    logic [1:0] mem [N];
    logic [1:0] shadow [N];
    logic [RW-1:0] row_l = '0;
    logic [CW-1:0] col_l0 = '0, col_l1 = '0;
    assign mem_dq[0] = (!row_stb_n && !col_stb_n[0] && !out_en_n && wr_en_n) ? mem[{row_l, col_l0}][0] : 1'bz;
    assign mem_dq[1] = (!row_stb_n && !col_stb_n[1] && !out_en_n && wr_en_n) ? mem[{row_l, col_l1}][1] : 1'bz;

    int n_chk = 0, n_bad = 0;
    int ras_falls = 0, cbr_cnt = 0, test_bad = 0, weoe_bad = 0, late_we = 0, wdat_bad = 0;
    int lo_len = 0, hi_len = 0, c0_len = 0, lo_min = 1000, hi_min = 1000, c0_min = 1000, lo_max = 0;
    bit seen_rise = 0, done = 0;
    logic p_ras = 1, p_we = 1;
    logic [1:0] p_cas = 2'b11;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !row_stb_n) begin
                if (col_stb_n == 2'b00) begin
                    cbr_cnt++;
                    if (!wr_en_n) test_bad++;
                end else begin
                    row_l = mem_addr[RW-1:0];
                    ras_falls++;
                end
                if (seen_rise && hi_len < hi_min) hi_min = hi_len;
                hi_len = 0;
            end
            if (!p_ras && row_stb_n) begin
                if (lo_len < lo_min) lo_min = lo_len;
                lo_len = 0;
                seen_rise = 1;
            end
            if (!row_stb_n) begin lo_len++; if (lo_len > lo_max) lo_max = lo_len; end
            else hi_len++;
            for (int i = 0; i < 2; i++) begin
                if (p_cas[i] && !col_stb_n[i] && !row_stb_n) begin
                    if (i == 0) col_l0 = mem_addr[CW-1:0]; else col_l1 = mem_addr[CW-1:0];
                    if (!wr_en_n) begin
                        if (p_we) late_we++;
                        if (mem_dq[i] !== 1'b0 && mem_dq[i] !== 1'b1) wdat_bad++;
                        mem[{row_l, mem_addr[CW-1:0]}][i] = mem_dq[i];
                    end
                end
            end
            if (!col_stb_n[0]) c0_len++;
            else if (p_cas[0] == 1'b0) begin
                if (c0_len < c0_min) c0_min = c0_len;
                c0_len = 0;
            end
            if (!wr_en_n && !out_en_n) weoe_bad++;
            p_ras = row_stb_n; p_cas = col_stb_n; p_we = wr_en_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input int a, input logic [1:0] dat,
                          input logic [1:0] ln, output logic [1:0] rd);
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = AWT'(a); req_wdata = dat; req_lane = ln;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        rd = 2'b00;
        if (we) begin
            for (int i = 0; i < 2; i++) if (ln[i]) shadow[a][i] = dat[i];
        end else begin
            while (!rsp_valid) @(negedge clk);
            rd = rsp_rdata;
        end
    endtask

    task automatic rd_chk(input int a, input logic [1:0] ln, input string req);
        logic [1:0] r;
        access(0, a, 2'b00, ln, r);
        chk(r === (shadow[a] & ln), req, int'(r), int'(shadow[a] & ln));
    endtask

    initial begin
        logic [1:0] r;
        int f0;
        for (int i = 0; i < N; i++) begin mem[i] = 2'(i * 7); shadow[i] = 2'(i * 7); end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(row_stb_n === 1 && col_stb_n === 2'b11 && wr_en_n === 1 && out_en_n === 1,
            "R11 strobes", int'({row_stb_n, col_stb_n, wr_en_n, out_en_n}), 31);
        chk(mem_dq === 2'bzz && req_ready === 1, "R11 bus/ready", int'(req_ready), 1);
        // R5 page hit: one row opening for three accesses
        f0 = ras_falls;
        access(1, 8, 2'b10, 2'b11, r);
        access(1, 9, 2'b01, 2'b11, r);
        rd_chk(9, 2'b11, "R5 data");
        chk(ras_falls - f0 == 1, "R5 row falls", ras_falls - f0, 1);
        // R6 miss opens another row once
        f0 = ras_falls;
        rd_chk(6'h30, 2'b11, "R6 data");
        chk(ras_falls - f0 == 1, "R6 row falls", ras_falls - f0, 1);
        // R1 R2 full sweep, row-major
        for (int a = 0; a < N; a++) access(1, a, 2'((a * 3 + 1) ^ (a >> 3)), 2'b11, r);
        for (int a = 0; a < N; a++) rd_chk(a, 2'b11, "R1 R2 sweep");
        // R6 column-major: every access changes row
        f0 = ras_falls;
        for (int c = 0; c < (1 << CW); c++)
            for (int rr = 0; rr < (1 << RW); rr++) rd_chk((rr << CW) | c, 2'b11, "R6 cm data");
        chk(ras_falls - f0 == N, "R6 miss count", ras_falls - f0, N);
        // R4 lane writes, R2 masked reads
        for (int a = 0; a < 16; a++) begin
            access(1, a * 4, ~shadow[a * 4], (a % 2 == 0) ? 2'b01 : 2'b10, r);
            rd_chk(a * 4, 2'b11, "R4 lane write");
            rd_chk(a * 4, (a % 2 == 0) ? 2'b10 : 2'b01, "R2 lane read");
        end
        // R10 refresh with a row open
        f0 = cbr_cnt;
        access(0, 5, 2'b00, 2'b11, r);
        @(negedge clk);
        ref_req = 1;
        while (!ref_done) @(negedge clk);
        ref_req = 0;
        chk(cbr_cnt - f0 == 1, "R10 refresh count", cbr_cnt - f0, 1);
        chk(test_bad == 0, "R10 write strobe high", test_bad, 0);
        f0 = ras_falls;
        rd_chk(5, 2'b11, "R10 data kept");
        chk(ras_falls - f0 == 1, "R10 row reopened", ras_falls - f0, 1);
        for (int a = 0; a < N; a++) rd_chk(a, 2'b11, "R10 contents");
        // R9 idle with open row
        repeat (300) @(negedge clk);
        chk(row_stb_n === 1, "R9 row closed", int'(row_stb_n), 1);
        chk(lo_max <= MAX_C, "R9 max low", lo_max, MAX_C);
        chk(lo_min >= RAS_C, "R7 min low", lo_min, RAS_C);
        chk(hi_min >= RP_C, "R7 min precharge", hi_min, RP_C);
        chk(c0_min >= CAS_C, "R8 min col low", c0_min, CAS_C);
        chk(weoe_bad == 0, "R3 oe during write", weoe_bad, 0);
        chk(late_we == 0, "R3 early write", late_we, 0);
        chk(wdat_bad == 0, "R3 data driven", wdat_bad, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule